// File: doc/BRIEF.md
# Protected Parallel Latched Driver Controller

This block is the synchronous control logic for a protected eight-channel low-side driver. It takes parallel data inputs that are captured into per-channel latches under a load control, and a clear control. One enable pin serves two purposes: it turns the outputs on or off, and it also resets faults. The block drives one on/off control per output stage, and an active-low fault flag.

Protection works at two levels. Each channel has its own over-current comparator input. A comparator assertion shuts that channel down only if the assertion lasts a programmable number of clock cycles, so short inrush spikes are ignored. A shutdown stays latched until the enable pin is pulsed high, an undervoltage condition occurs, or the block is reset. An over-temperature input turns every output off while it is present and is never latched. An undervoltage input behaves exactly like a high enable pin.

All asynchronous inputs pass through a two-stage synchronizer before any logic uses them.

Top module: `latchdrv_ctrl`

## Requirements
- R1: While the synchronized `load` is 1 and `wipe` is 0, the latch bank takes `din` on each clock edge, with bit i going to channel i. While `load` is 0, the latches keep their value.
- R2: A synchronized `wipe` of 1 sets every latch to 0 (off) on the next edge, whatever `load` and `din` are.
- R3: While the synchronized `en_rst` is 1, `drv_on` is all zeros. While it is 0 and no other off condition holds, `drv_on[i]` equals latch i.
- R4: A latched over-current fault on channel i forces `drv_on[i]` to 0 and leaves the other channels unaffected.
- R5: A channel's fault latches only when its synchronized `oc_det` bit has been 1 on `QUAL_CYC` consecutive clock edges. Any edge on which the bit is 0 restarts the count. A run of `QUAL_CYC-1` edges does not latch a fault.
- R6: A latched fault stays set, even after `oc_det` drops, until the synchronized `en_rst` is 1 or `rst` is applied.
- R7: While the synchronized `hot` is 1, `drv_on` is all zeros and `fault_n` is 0. When `hot` returns to 0, the previous behaviour resumes with no reset pulse.
- R8: A synchronized `low_vdd` of 1 forces `drv_on` to all zeros and clears every latched over-current fault, exactly as `en_rst` does.
- R9: `fault_n` is 0 exactly when some channel holds a latched fault or the synchronized `hot` is 1. Otherwise it is 1.
- R10: A synchronous `rst` puts all latches at 0, clears all faults, and makes `drv_on` all zeros and `fault_n` 1 after the first edge with `rst` high.
- R11: Each input passes through two flops before it is used. A change in `en_rst`, `hot` or `low_vdd` reaches the outputs 2 edges later. A change in `din`, `load` or `wipe` reaches the outputs 3 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (models supply power-up) |
| din | input | NCH | Parallel channel data, 1 = on |
| load | input | 1 | Latch load; latches follow din while high |
| wipe | input | 1 | Clears all latches to off while high |
| en_rst | input | 1 | High: outputs off and latched faults reset |
| oc_det | input | NCH | Per-channel over-current comparator outputs |
| hot | input | 1 | Over-temperature indication |
| low_vdd | input | 1 | Undervoltage indication |
| drv_on | output | NCH | Per-channel output stage on control |
| fault_n | output | 1 | Active-low fault flag |

## Verification
The enable, temperature and undervoltage inputs reach the outputs two edges after they change. Data, load and clear reach them three edges after they change. An over-current fault appears on the edge after the `QUAL_CYC`-th consecutive synchronized high sample. The bench models each of these as a two-stage delay of the raw inputs followed by behavioural state updates at each edge. It compares `drv_on` and `fault_n` on every falling edge, so every latency is checked exactly and not just eventually. Comparator pulses of exactly `QUAL_CYC-1` and `QUAL_CYC` cycles test the filter boundary in both directions.

// File: rtl/latchdrv_pkg.sv
package latchdrv_pkg;

    // synchronized single-bit controls
    typedef struct packed {
        logic load;
        logic wipe;
        logic en_rst;
        logic low_vdd;
        logic hot;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // outputs gated off as a whole
    function automatic logic all_off(ctl_t c);
        return c.en_rst | c.low_vdd | c.hot;
    endfunction

    // latched faults are released
    function automatic logic fault_release(ctl_t c);
        return c.en_rst | c.low_vdd;
    endfunction

endpackage

// File: rtl/ld_sync.sv
module ld_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] s_out
);
    logic [W-1:0] stg1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg1  <= '0;
            s_out <= '0;
        end else begin
            stg1  <= a_in;
            s_out <= stg1;
        end
    end
endmodule

// File: rtl/ld_latch_bank.sv
module ld_latch_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] d,
    input  logic           ld,
    input  logic           clr,
    output logic [NCH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (clr)  q <= '0;
        else if (ld)   q <= d;
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> (q == $past(d)));

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (!ld && !clr) |=> $stable(q));

    assert_wipe_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));
endmodule

// File: rtl/ld_oc_chan.sv
module ld_oc_chan #(
    parameter int QUAL_CYC = 100,
    localparam int CW = $clog2(QUAL_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic oc,
    input  logic rel,
    output logic fault
);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || rel) begin
            run   <= '0;
            fault <= 1'b0;
        end else if (!oc) begin
            run   <= '0;
        end else if (run == LAST) begin
            fault <= 1'b1;
        end else begin
            run   <= run + 1'b1;
        end
    end

    assert_trip_needs_oc_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> $past(oc));

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (fault && !rel) |=> fault);

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        rel |=> !fault);
endmodule

// File: rtl/latchdrv_ctrl.sv
module latchdrv_ctrl
    import latchdrv_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int QUAL_CYC = 100
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] din,
    input  logic           load,
    input  logic           wipe,
    input  logic           en_rst,
    input  logic [NCH-1:0] oc_det,
    input  logic           hot,
    input  logic           low_vdd,
    output logic [NCH-1:0] drv_on,
    output logic           fault_n
);
    localparam int SW = 2 * NCH + CTL_W;

    ctl_t           ctl_a, ctl_s;
    logic [NCH-1:0] din_s, oc_s, lat, flt;

    assign ctl_a = '{load: load, wipe: wipe, en_rst: en_rst,
                     low_vdd: low_vdd, hot: hot};

    ld_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .a_in  ({oc_det, din, ctl_a}),
        .s_out ({oc_s, din_s, ctl_s})
    );

    ld_latch_bank #(.NCH(NCH)) u_bank (
        .clk (clk),
        .rst (rst),
        .d   (din_s),
        .ld  (ctl_s.load),
        .clr (ctl_s.wipe),
        .q   (lat)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        ld_oc_chan #(.QUAL_CYC(QUAL_CYC)) u_oc (
            .clk   (clk),
            .rst   (rst),
            .oc    (oc_s[i]),
            .rel   (fault_release(ctl_s)),
            .fault (flt[i])
        );
    end

    assign drv_on  = lat & ~flt & {NCH{~all_off(ctl_s)}};
    assign fault_n = ~(|flt | ctl_s.hot);

    // a fault may only appear after the comparator was seen high
    assert_flag_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> (ctl_s.hot || $past(|oc_s)));
endmodule

// File: tb/latchdrv_ctrl_tb.sv
module latchdrv_ctrl_tb;
    localparam int N  = 8;
    localparam int QC = 16;

    logic clk = 0, rst = 1;
    logic [N-1:0] din = '0, oc_det = '0;
    logic load = 0, wipe = 0, en_rst = 0, hot = 0, low_vdd = 0;
    logic [N-1:0] drv_on;
    logic fault_n;

    always #10 clk = ~clk;

    latchdrv_ctrl #(.NCH(N), .QUAL_CYC(QC)) u_dut (
        .clk(clk), .rst(rst), .din(din), .load(load), .wipe(wipe),
        .en_rst(en_rst), .oc_det(oc_det), .hot(hot), .low_vdd(low_vdd),
        .drv_on(drv_on), .fault_n(fault_n)
    );

    // behavioural reference: raw inputs delayed by two clocks
    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit started = 0;
    string phase = "R10";
    logic [N-1:0] q_din[2], q_oc[2];
    logic q_ld[2], q_wp[2], q_en[2], q_ht[2], q_uv[2];
    logic [N-1:0] m_lat, m_flt;
    int m_run[N];

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            started = 1;
            m_lat = '0; m_flt = '0;
            for (int i = 0; i < N; i++) m_run[i] = 0;
            for (int k = 0; k < 2; k++) begin
                q_din[k] = '0; q_oc[k] = '0; q_ld[k] = 0; q_wp[k] = 0;
                q_en[k] = 0; q_ht[k] = 0; q_uv[k] = 0;
            end
        end else begin
            if (q_wp[1]) m_lat = '0;
            else if (q_ld[1]) m_lat = q_din[1];
            for (int i = 0; i < N; i++) begin
                if (q_en[1] || q_uv[1]) begin
                    m_run[i] = 0; m_flt[i] = 0;
                end else if (!q_oc[1][i]) begin
                    m_run[i] = 0;
                end else begin
                    m_run[i]++;
                    if (m_run[i] >= QC) m_flt[i] = 1;
                end
            end
            q_din[1] = q_din[0]; q_oc[1] = q_oc[0]; q_ld[1] = q_ld[0];
            q_wp[1] = q_wp[0]; q_en[1] = q_en[0]; q_ht[1] = q_ht[0]; q_uv[1] = q_uv[0];
            q_din[0] = din; q_oc[0] = oc_det; q_ld[0] = load;
            q_wp[0] = wipe; q_en[0] = en_rst; q_ht[0] = hot; q_uv[0] = low_vdd;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            logic [N-1:0] e_on;
            logic e_fn;
            e_on = (q_en[1] || q_uv[1] || q_ht[1]) ? '0 : (m_lat & ~m_flt);
            e_fn = !((|m_flt) || q_ht[1]);
            n_cmp++;
            if (drv_on !== e_on || fault_n !== e_fn) begin
                n_bad++;
                $display("FAIL %s cycle %0d: drv_on=%b fault_n=%b expected drv_on=%b fault_n=%b",
                         phase, cyc, drv_on, fault_n, e_on, e_fn);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    initial begin
        step(3);
        phase = "R10"; rst = 0; step(4);
        // R11 / R1: transparent load, then hold
        phase = "R1"; din = 8'hA5; load = 1; step(1);
        phase = "R11"; load = 0; din = 8'h00; step(5);
        phase = "R1"; din = 8'h3C; step(4);
        load = 1; din = 8'h81; step(2); din = 8'h7E; step(2); load = 0; step(4);
        // R2: wipe wins over load
        phase = "R2"; din = 8'hFF; load = 1; wipe = 1; step(2);
        wipe = 0; step(3); load = 0; step(3);
        wipe = 1; step(1); wipe = 0; step(4);
        // R3: enable pin gates outputs
        phase = "R3"; din = 8'h5A; load = 1; step(1); load = 0; step(4);
        en_rst = 1; step(4); en_rst = 0; step(4);
        // R5: short run does not trip, exact run trips
        phase = "R5"; oc_det = 8'h08; step(QC - 1); oc_det = 8'h00; step(4);
        oc_det = 8'h08; step(QC - 3); oc_det = 0; step(1); oc_det = 8'h08; step(QC - 2);
        oc_det = 0; step(4);
        phase = "R4"; din = 8'hFF; load = 1; step(1); load = 0; step(3);
        oc_det = 8'h08; step(QC); oc_det = 0; step(5);
        // R6: stays latched
        phase = "R6"; step(10);
        en_rst = 1; step(1); en_rst = 0; step(5);
        // R7: over-temperature not latched
        phase = "R7"; hot = 1; step(5); hot = 0; step(5);
        // R9: fault plus over-temperature combined
        phase = "R9"; oc_det = 8'h81; step(QC + 2); oc_det = 0; hot = 1; step(4);
        hot = 0; step(4);
        // R8: undervoltage clears faults
        phase = "R8"; low_vdd = 1; step(3); low_vdd = 0; step(5);
        // R10: reset mid-fault
        phase = "R10"; oc_det = 8'h10; step(QC + 2); oc_det = 0; step(2);
        rst = 1; step(2); rst = 0; step(6);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule